// File: doc/BRIEF.md
# SPI Serial Flash Slave

This block lets a host treat a small on-chip byte array as if it were a serial firmware flash. It is an SPI mode-0 slave: the host drives the serial clock, an active-low select and the data-in line. The block shifts a reply out most significant bit first. The reply changes after each falling clock edge and is valid at the next rising edge. The SPI pins are sampled by the block's own system clock through a synchronizer, so the serial clock must run several times slower than the system clock.

Each selection starts with a command byte. A read or a page write is followed by three address bytes, most significant first, and then by a data phase. During that phase the internal address moves forward one byte per transfer. A write-enable latch guards page writes. The write-enable command can set the latch only while the write-permit strap is high. Software can observe the latch through the status command. Accesses at or beyond the array size are dropped rather than wrapped.

Top module: `spi_flash_slave`

## Requirements
- R1: Opcodes are 0x03 read, 0x0A page write, 0x06 write enable, 0x04 write disable and 0x05 status. Read and page write each take exactly three address bytes, most significant byte first, before their data phase.
- R2: In a read, the byte returned during the first transfer after the third address byte is the byte at the received address. Each further transfer returns the next address in turn.
- R3: In an accepted page write, each data byte is stored at the current address, and the address then advances by one.
- R4: A page-write byte aimed at an address at or beyond MEM_BYTES changes no memory. A read of such an address returns 0xFF and does not advance the address.
- R5: Write enable sets the latch only while wr_allow is high. Write disable always clears the latch.
- R6: A page-write opcode received while the latch is clear is not entered. Every byte returned for the rest of that selection is 0x00, the following bytes are decoded as commands, and memory is unchanged.
- R7: After the status opcode, every further byte of the selection returns 0x02 when the latch is set and 0x00 when it is clear.
- R8: Opcode 0x00 and unknown opcodes change nothing. The decoder stays in command wait, so the next byte of the same selection is decoded as a new command.
- R9: Raising chip select ends any command and returns the decoder to command wait. If a page write was accepted in that selection, the latch is also cleared. Other commands leave the latch as it is.
- R10: The reply is 0x00 during the command byte and the address bytes, and spi_miso is low while the block is deselected.
- R11: After reset the latch is clear, spi_miso is low and every memory byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| wr_allow | input | 1 | Write-permit strap; high lets write enable set the latch |

## Verification
The hardest state to reach is the end of the array. A page write or read has to cross from the last valid byte into the dropped region within one selection. The bench does this by starting a write two bytes below MEM_BYTES and streaming past it, then reading back from three bytes below the limit. A second hard case is a selection that ends in the middle of an accepted page write, during the address bytes, which must still clear the latch. The stimulus raises chip select after one address byte and then issues a status read. A behavioural model decides every returned byte, so strap, latch and selection sequences that arise only after several commands are compared byte for byte.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_PGWR = 8'h0A;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;

    localparam logic [7:0] IDLE_BYTE = 8'h00;
    localparam logic [7:0] NO_DATA   = 8'hFF;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_STAT = 2'd3
    } phase_t;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wr_req_t;

    function automatic logic [7:0] status_byte(input logic latch);
        return {6'b0, latch, 1'b0};
    endfunction

endpackage

// File: rtl/sfs_pin_sync.sv
module sfs_pin_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_act,
    input  logic       mosi,
    input  logic [7:0] tx_next,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       miso
);
    logic       sck_q;
    logic       cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rise, fall, cs_start;

    assign rise     = cs_act & sck & ~sck_q;
    assign fall     = cs_act & ~sck & sck_q;
    assign cs_start = cs_act & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b0;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            sck_q    <= sck;
            cs_q     <= cs_act;
            rx_valid <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sr   <= {rx_sr[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_data  <= {rx_sr, mosi};
                end
            end
            if (cs_start) begin
                tx_sr <= tx_next;
            end else if (fall) begin
                if (bit_cnt == 3'd0) tx_sr <= tx_next;
                else                 tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso = cs_act ? tx_sr[7] : 1'b0;
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import flash_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              wr_allow,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr_req,
    output logic [7:0]        tx_next,
    output logic              wel,
    output phase_t            phase,
    output op_t               op,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W:0] SIZE_L  = (ADDR_W+1)'(MEM_BYTES);
    localparam logic [1:0]      ACNT_LAST = 2'(ADDR_BYTES - 1);

    logic [1:0]        acnt;
    logic [ADDR_W-1:0] addr_shift;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ok;
    logic              wr_ok;

    assign addr_shift = {addr[ADDR_W-9:0], rx_data};
    assign fetch_addr = (phase == PH_ADDR) ? addr_shift : addr;
    assign fetch_ok   = {1'b0, fetch_addr} < SIZE_L;
    assign wr_ok      = {1'b0, addr} < SIZE_L;
    assign rd_addr    = fetch_addr;

    always_comb begin
        wr_req.en   = cs_act & rx_valid & (phase == PH_DATA) & (op == OP_WR) & wr_ok;
        wr_req.addr = addr;
        wr_req.data = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CMD;
            op      <= OP_RD;
            acnt    <= '0;
            addr    <= '0;
            wel     <= 1'b0;
            tx_next <= IDLE_BYTE;
        end else if (!cs_act) begin
            if (op == OP_WR && (phase == PH_ADDR || phase == PH_DATA))
                wel <= 1'b0;
            phase   <= PH_CMD;
            acnt    <= '0;
            tx_next <= IDLE_BYTE;
        end else if (rx_valid) begin
            unique case (phase)
                PH_CMD: begin
                    tx_next <= IDLE_BYTE;
                    unique case (rx_data)
                        OPC_READ: begin
                            phase <= PH_ADDR;
                            op    <= OP_RD;
                            acnt  <= '0;
                            addr  <= '0;
                        end
                        OPC_PGWR: begin
                            if (wel) begin
                                phase <= PH_ADDR;
                                op    <= OP_WR;
                                acnt  <= '0;
                                addr  <= '0;
                            end
                        end
                        OPC_WREN: if (wr_allow) wel <= 1'b1;
                        OPC_WRDI: wel <= 1'b0;
                        OPC_RDSR: begin
                            phase   <= PH_STAT;
                            tx_next <= status_byte(wel);
                        end
                        default: ;
                    endcase
                end
                PH_ADDR: begin
                    addr    <= addr_shift;
                    acnt    <= acnt + 2'd1;
                    tx_next <= IDLE_BYTE;
                    if (acnt == ACNT_LAST) begin
                        phase <= PH_DATA;
                        if (op == OP_RD) begin
                            if (fetch_ok) begin
                                tx_next <= rd_data;
                                addr    <= fetch_addr + 1'b1;
                            end else begin
                                tx_next <= NO_DATA;
                            end
                        end
                    end
                end
                PH_DATA: begin
                    if (op == OP_WR) begin
                        tx_next <= IDLE_BYTE;
                        if (wr_ok) addr <= addr + 1'b1;
                    end else if (fetch_ok) begin
                        tx_next <= rd_data;
                        addr    <= fetch_addr + 1'b1;
                    end else begin
                        tx_next <= NO_DATA;
                    end
                end
                PH_STAT: tx_next <= status_byte(wel);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfs_mem.sv
module sfs_mem
    import flash_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int              IDX_W  = $clog2(MEM_BYTES);
    localparam logic [ADDR_W:0] SIZE_L = (ADDR_W+1)'(MEM_BYTES);

    logic [7:0] store [MEM_BYTES];

    assign rd_data = ({1'b0, rd_addr} < SIZE_L) ? store[rd_addr[IDX_W-1:0]] : NO_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) store[i] <= '0;
        end else if (wr_req.en && ({1'b0, wr_req.addr} < SIZE_L)) begin
            store[wr_req.addr[IDX_W-1:0]] <= wr_req.data;
        end
    end
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
    import flash_pkg::*;
#(
    parameter int MEM_BYTES   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wr_allow
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_act, mosi_s;
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic [7:0]        tx_next;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] addr;
    wr_req_t           wr_req;
    logic              wel;
    phase_t            phase;
    op_t               op;
    logic              mem_we;

    sfs_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sck, spi_cs_n, spi_mosi}),
        .q  (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_act = ~pins_s[1];
    assign mosi_s = pins_s[0];

    sfs_shifter i_shift (
        .clk     (clk),
        .rst     (rst),
        .sck     (sck_s),
        .cs_act  (cs_act),
        .mosi    (mosi_s),
        .tx_next (tx_next),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .miso    (spi_miso)
    );

    sfs_ctrl #(.MEM_BYTES(MEM_BYTES)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_act  (cs_act),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .wr_allow(wr_allow),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .tx_next (tx_next),
        .wel     (wel),
        .phase   (phase),
        .op      (op),
        .addr    (addr)
    );

    sfs_mem #(.MEM_BYTES(MEM_BYTES)) i_mem (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    assign mem_we = wr_req.en;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
    import flash_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              wr_allow,
    input logic              wel,
    input phase_t            phase,
    input op_t               op,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_we
);
    localparam logic [ADDR_W:0] SIZE_L = (ADDR_W+1)'(MEM_BYTES);

    AST_LATCH_NEEDS_STRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> wr_allow); // R5

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> phase == PH_CMD); // R9

    AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wel); // R3

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ({1'b0, addr} < SIZE_L)); // R4

    AST_WRITE_STEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> addr == $past(addr) + 1'b1); // R3

    AST_LATCH_DROPS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && op == OP_WR && phase == PH_DATA) |=> !wel); // R9
endmodule

bind spi_flash_slave sfs_checker #(.MEM_BYTES(MEM_BYTES)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_act  (cs_act),
    .wr_allow(wr_allow),
    .wel     (wel),
    .phase   (phase),
    .op      (op),
    .addr    (addr),
    .mem_we  (mem_we)
);

// File: tb/test_spi_flash_slave.sv
module test_spi_flash_slave;
    localparam int MEMB = 256;
    localparam int HALF = 6;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst, sck, cs_n, mosi, wr_allow;
    logic miso;

    always #4 clk = ~clk;

    spi_flash_slave #(.MEM_BYTES(MEMB), .SYNC_STAGES(2)) i_spi_flash_slave (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .wr_allow(wr_allow)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    string req   = "R11";

    // behavioural reference: phase 0 cmd, 1 addr, 2 data, 3 status
    logic [7:0]  ref_mem [MEMB];
    int          ref_phase = 0;
    int          ref_acnt  = 0;
    bit          ref_wr    = 0;
    int unsigned ref_addr  = 0;
    bit          ref_wel   = 0;
    logic [7:0]  ref_resp  = 8'h00;

    task automatic check8(input string r, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic void ref_fetch();
        if (ref_addr < MEMB) begin
            ref_resp = ref_mem[ref_addr];
            ref_addr = ref_addr + 1;
        end else begin
            ref_resp = 8'hFF;
        end
    endfunction

    function automatic void ref_step(input logic [7:0] b);
        case (ref_phase)
            0: begin
                ref_resp = 8'h00;
                case (b)
                    8'h03: begin ref_phase = 1; ref_wr = 0; ref_acnt = 0; ref_addr = 0; end
                    8'h0A: if (ref_wel) begin ref_phase = 1; ref_wr = 1; ref_acnt = 0; ref_addr = 0; end
                    8'h06: if (wr_allow) ref_wel = 1;
                    8'h04: ref_wel = 0;
                    8'h05: begin ref_phase = 3; ref_resp = ref_wel ? 8'h02 : 8'h00; end
                    default: ;
                endcase
            end
            1: begin
                ref_addr = ((ref_addr << 8) | b) & 32'h00FF_FFFF;
                ref_acnt++;
                ref_resp = 8'h00;
                if (ref_acnt == 3) begin
                    ref_phase = 2;
                    if (!ref_wr) ref_fetch();
                end
            end
            2: begin
                if (ref_wr) begin
                    ref_resp = 8'h00;
                    if (ref_addr < MEMB) begin
                        ref_mem[ref_addr] = b;
                        ref_addr = ref_addr + 1;
                    end
                end else begin
                    ref_fetch();
                end
            end
            default: ref_resp = ref_wel ? 8'h02 : 8'h00;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b);
        logic [7:0] got;
        logic [7:0] exp;
        exp = ref_resp;
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            got[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        check8(req, got, exp);
        ref_step(b);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(2);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF + 4);
        if (ref_wr && (ref_phase == 1 || ref_phase == 2)) ref_wel = 0;
        ref_phase = 0;
        ref_resp  = 8'h00;
        check8("R10", {7'b0, miso}, 8'h00); // R10: quiet while deselected
    endtask

    task automatic cmd_addr(input logic [7:0] opc, input logic [23:0] a);
        xfer(opc);
        xfer(a[23:16]);
        xfer(a[15:8]);
        xfer(a[7:0]);
    endtask

    task automatic one_cmd(input logic [7:0] opc);
        sel(); xfer(opc); desel();
    endtask

    task automatic status_read(input int n);
        sel(); xfer(8'h05);
        for (int i = 0; i < n; i++) xfer(8'h00);
        desel();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEMB; i++) ref_mem[i] = 8'h00;
        rst = 1'b1; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; wr_allow = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R11: reset state
        req = "R11";
        check8("R11", {7'b0, miso}, 8'h00);
        sel(); cmd_addr(8'h03, 24'h000000);
        for (int i = 0; i < 4; i++) xfer(8'h00);
        desel();
        status_read(1);

        // R5: strap low blocks write enable
        req = "R5";
        one_cmd(8'h06);
        status_read(2);

        // R6: page write rejected with latch clear
        req = "R6";
        sel(); cmd_addr(8'h0A, 24'h000020);
        xfer(8'h5A); xfer(8'h05); xfer(8'h11);
        desel();
        req = "R6";
        sel(); cmd_addr(8'h03, 24'h000020);
        xfer(8'h00); xfer(8'h00);
        desel();

        // R5/R7: strap high enables latch, status repeats
        wr_allow = 1'b1;
        req = "R5";
        one_cmd(8'h06);
        req = "R7";
        status_read(3);

        // R3: page write, then R9 latch cleared
        req = "R3";
        sel(); cmd_addr(8'h0A, 24'h000010);
        xfer(8'hA1); xfer(8'hB2); xfer(8'hC3); xfer(8'hD4); xfer(8'hE5);
        desel();
        req = "R9";
        status_read(1);

        // R2: read stream crossing written data
        req = "R2";
        sel(); cmd_addr(8'h03, 24'h00000E);
        for (int i = 0; i < 8; i++) xfer(8'h00);
        desel();

        // R5: write disable clears latch
        req = "R5";
        one_cmd(8'h06);
        one_cmd(8'h04);
        status_read(1);

        // R4: writes crossing the end of the array are dropped
        req = "R4";
        one_cmd(8'h06);
        sel(); cmd_addr(8'h0A, 24'(MEMB - 2));
        xfer(8'h77); xfer(8'h88); xfer(8'h99); xfer(8'hAA);
        desel();
        sel(); cmd_addr(8'h03, 24'(MEMB - 3));
        for (int i = 0; i < 5; i++) xfer(8'h00);
        desel();

        // R1: address bytes most significant first
        req = "R1";
        one_cmd(8'h06);
        sel(); cmd_addr(8'h0A, 24'h000030); xfer(8'h3C); desel();
        sel(); cmd_addr(8'h03, 24'h300000); xfer(8'h00); desel();
        sel(); cmd_addr(8'h03, 24'h000030); xfer(8'h00); desel();

        // R8: null and unknown opcodes, then status in same selection
        req = "R8";
        one_cmd(8'h06);
        sel(); xfer(8'h00); xfer(8'h77); xfer(8'hE1); xfer(8'h05); xfer(8'h00); desel();

        // R9: read does not clear latch; aborted page write does
        req = "R9";
        sel(); cmd_addr(8'h03, 24'h000010); xfer(8'h00); desel();
        status_read(1);
        sel(); xfer(8'h0A); xfer(8'h00); desel();
        status_read(1);

        // R10: replies during command and address bytes are zero
        req = "R10";
        one_cmd(8'h06);
        sel(); cmd_addr(8'h0A, 24'h000040); xfer(8'h01); desel();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule